// File: doc/BRIEF.md
# Bus Ownership Handshake Controller

This controller decides, one clock at a time, whether a bus master should ask for a shared external bus, take it, hold on to it with no work pending, or hand it back. It watches an internal access request, the arbiter's active-low grant, the bus's active-low busy line, an active-low request-hold level and an end-of-sequence flag. From these it drives an active-low bus request and an active-low bus-active (ownership) signal.

The bus counts as acquirable when grant is low and busy is high. A master that finishes its work while grant stays low keeps the bus in a parked state, so a later access starts with no arbitration delay. When grant is withdrawn during an access, ownership is only surrendered at a sequence boundary: the end-of-sequence flag is held low through the read half of a locked read-modify-write, so the pair is never split across owners. All inputs arrive already synchronous to the controller clock; both outputs come from registers and follow the state with one clock of latency.

Top module: `bus_own_ctrl`

## Requirements
- R1: While reset is high the state becomes idle and both outputs are high one edge later; after reset the idle state holds while the request is low and the bus is not acquirable.
- R2: From idle, with the bus acquirable (grant_n_i low, busy_n_i high), a request moves to active and no request moves to parked; with the bus not acquirable, a request moves to waiting.
- R3: From waiting, a request with the bus acquirable moves to active; a request with the bus not acquirable stays in waiting.
- R4: Waiting never moves to idle or parked: a dropped request while waiting leaves the state in waiting, whatever grant and busy do.
- R5: From parked, a request while grant is low moves to active; grant going high moves to idle; parked never moves to waiting; no request with grant low stays parked.
- R6: From active with grant low, a request keeps the state active and no request moves to parked.
- R7: From active with grant high, no request moves to idle; a request with end-of-sequence high moves to waiting; a request with end-of-sequence low stays active (locked sequence kept).
- R8: Outputs are registered and show the state of the previous cycle as {breq_n_o, bact_n_o}: active = {0,0}, waiting = {0,1}, parked = {hold, 0}, idle = {hold, 1}.
- R9: In idle and parked, breq_n_o equals the hold_n_i level sampled at the same edge that registers the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_req_i | input | 1 | Internal request for an external access, active high |
| grant_n_i | input | 1 | Bus grant from the arbiter, active low |
| busy_n_i | input | 1 | Bus busy, active low (high means the bus is free) |
| hold_n_i | input | 1 | Request-hold level copied to the bus request in idle and parked |
| seq_end_i | input | 1 | End-of-sequence flag, low during the read half of a locked access |
| breq_n_o | output | 1 | Bus request, active low, registered |
| bact_n_o | output | 1 | Bus active (ownership), active low, registered |

## Verification
The block has no parameters, so the bench builds its single configuration and every state and arc is within reach in a few cycles. The directed tasks drive each arc out of every state, including the forbidden ones (request dropped while waiting, request raised in parked with grant withdrawn) and the locked sequence where grant is removed while end-of-sequence is low. Hold-level tests in idle and parked confirm the request output follows hold_n_i while the active output tells the two states apart.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;

    typedef enum logic [1:0] {
        OWN_IDLE   = 2'd0,
        OWN_WAIT   = 2'd1,
        OWN_ACTIVE = 2'd2,
        OWN_PARK   = 2'd3
    } own_st_e;

    typedef struct packed {
        logic req;       // internal access request
        logic grant_n;   // arbiter grant, active low
        logic busy_n;    // bus busy, active low
        logic seq_end;   // sequence boundary reached
    } own_in_t;

    typedef struct packed {
        logic breq_n;
        logic bact_n;
    } own_out_t;

    localparam own_out_t OUT_RESET = '{breq_n: 1'b1, bact_n: 1'b1};

    // Bus can be taken: granted and nobody else driving it.
    function automatic logic bus_free(input own_in_t in);
        return !in.grant_n && in.busy_n;
    endfunction

    // Pin levels for a given state; hold_n passes through when not bidding.
    function automatic own_out_t out_encode(input own_st_e st, input logic hold_n);
        own_out_t o;
        unique case (st)
            OWN_ACTIVE: o = '{breq_n: 1'b0,   bact_n: 1'b0};
            OWN_WAIT:   o = '{breq_n: 1'b0,   bact_n: 1'b1};
            OWN_PARK:   o = '{breq_n: hold_n, bact_n: 1'b0};
            default:    o = '{breq_n: hold_n, bact_n: 1'b1};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/bus_own_nxt.sv
module bus_own_nxt
    import bus_own_pkg::*;
(
    input  own_st_e cur_st,
    input  own_in_t in,
    output own_st_e nxt_st
);
    logic free;

    always_comb begin
        free   = bus_free(in);
        nxt_st = cur_st;
        unique case (cur_st)
            OWN_IDLE: begin
                if (in.req)
                    nxt_st = free ? OWN_ACTIVE : OWN_WAIT;
                else if (free)
                    nxt_st = OWN_PARK;
            end
            OWN_WAIT: begin
                // Only exit is acquisition; a dropped request waits on.
                if (in.req && free)
                    nxt_st = OWN_ACTIVE;
            end
            OWN_ACTIVE: begin
                if (!in.grant_n) begin
                    if (!in.req)
                        nxt_st = OWN_PARK;
                end else if (!in.req) begin
                    nxt_st = OWN_IDLE;
                end else if (in.seq_end) begin
                    nxt_st = OWN_WAIT;
                end
            end
            OWN_PARK: begin
                if (in.grant_n)
                    nxt_st = OWN_IDLE;
                else if (in.req)
                    nxt_st = OWN_ACTIVE;
            end
            default: nxt_st = OWN_IDLE;
        endcase
    end
endmodule

// File: rtl/bus_own_out.sv
module bus_own_out
    import bus_own_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  own_st_e st,
    input  logic    hold_n,
    output own_out_t pins_q
);
    always_ff @(posedge clk) begin
        if (rst)
            pins_q <= OUT_RESET;
        else
            pins_q <= out_encode(st, hold_n);
    end
endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl
    import bus_own_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic acc_req_i,
    input  logic grant_n_i,
    input  logic busy_n_i,
    input  logic hold_n_i,
    input  logic seq_end_i,
    output logic breq_n_o,
    output logic bact_n_o
);
    own_in_t  in_w;
    own_st_e  state_q;
    own_st_e  state_d;
    own_out_t pins_q;

    assign in_w = '{req: acc_req_i, grant_n: grant_n_i,
                    busy_n: busy_n_i, seq_end: seq_end_i};

    bus_own_nxt i_nxt (
        .cur_st (state_q),
        .in     (in_w),
        .nxt_st (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= OWN_IDLE;
        else
            state_q <= state_d;
    end

    bus_own_out i_out (
        .clk    (clk),
        .rst    (rst),
        .st     (state_q),
        .hold_n (hold_n_i),
        .pins_q (pins_q)
    );

    assign breq_n_o = pins_q.breq_n;
    assign bact_n_o = pins_q.bact_n;
endmodule

// File: rtl/bus_own_chk.sv
module bus_own_chk
    import bus_own_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    acc_req_i,
    input logic    grant_n_i,
    input logic    busy_n_i,
    input logic    hold_n_i,
    input logic    seq_end_i,
    input logic    breq_n_o,
    input logic    bact_n_o,
    input own_st_e state_q
);
    // R1: reset forces idle on the next edge
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> state_q == OWN_IDLE);

    // R2: idle with request and acquirable bus takes ownership at once
    a_r2_idle_take: assert property (@(posedge clk) disable iff (rst)
        (state_q == OWN_IDLE && acc_req_i && !grant_n_i && busy_n_i)
        |=> state_q == OWN_ACTIVE);

    // R4: waiting is never abandoned for idle or parked
    a_r4_wait_no_drop: assert property (@(posedge clk) disable iff (rst)
        state_q == OWN_WAIT |=> (state_q == OWN_WAIT || state_q == OWN_ACTIVE));

    // R5: parked never goes straight to waiting
    a_r5_park_no_wait: assert property (@(posedge clk) disable iff (rst)
        state_q == OWN_PARK |=> state_q != OWN_WAIT);

    // R7: locked sequence keeps ownership while grant is withdrawn
    a_r7_locked_keep: assert property (@(posedge clk) disable iff (rst)
        (state_q == OWN_ACTIVE && acc_req_i && grant_n_i && !seq_end_i)
        |=> state_q == OWN_ACTIVE);

    // R8: active drives both outputs low one cycle later
    a_r8_active_pins: assert property (@(posedge clk) disable iff (rst)
        state_q == OWN_ACTIVE |=> (!breq_n_o && !bact_n_o));

    // R8: waiting requests but does not own
    a_r8_wait_pins: assert property (@(posedge clk) disable iff (rst)
        state_q == OWN_WAIT |=> (!breq_n_o && bact_n_o));

    // R9: parked passes hold level through and owns the bus
    a_r9_park_hold: assert property (@(posedge clk) disable iff (rst)
        state_q == OWN_PARK |=> (breq_n_o == $past(hold_n_i) && !bact_n_o));

    // R9: idle passes hold level through and does not own
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        state_q == OWN_IDLE |=> (breq_n_o == $past(hold_n_i) && bact_n_o));
endmodule

bind bus_own_ctrl bus_own_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_req_i (acc_req_i),
    .grant_n_i (grant_n_i),
    .busy_n_i  (busy_n_i),
    .hold_n_i  (hold_n_i),
    .seq_end_i (seq_end_i),
    .breq_n_o  (breq_n_o),
    .bact_n_o  (bact_n_o),
    .state_q   (state_q)
);

// File: tb/test_bus_own_ctrl.sv
module test_bus_own_ctrl;
    // Bench state codes, independent of the design's encoding
    localparam int S_IDLE = 0, S_WAIT = 1, S_ACT = 2, S_PARK = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_req_i = 1'b0, grant_n_i = 1'b1, busy_n_i = 1'b1;
    logic hold_n_i = 1'b1, seq_end_i = 1'b1;
    logic breq_n_o, bact_n_o;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    bus_own_ctrl i_bus_own_ctrl (
        .clk(clk), .rst(rst), .acc_req_i(acc_req_i), .grant_n_i(grant_n_i),
        .busy_n_i(busy_n_i), .hold_n_i(hold_n_i), .seq_end_i(seq_end_i),
        .breq_n_o(breq_n_o), .bact_n_o(bact_n_o)
    );

    function automatic logic [1:0] pins_for(input int s, input logic h);
        case (s)
            S_ACT:   return 2'b00;
            S_WAIT:  return 2'b01;
            S_PARK:  return {h, 1'b0};
            default: return {h, 1'b1};
        endcase
    endfunction

    task automatic check(input string tag, input logic [1:0] exp);
        n_run++;
        if ({breq_n_o, bact_n_o} !== exp) begin
            n_fail++;
            $display("FAIL %s: {breq_n,bact_n} actual=%b expected=%b",
                     tag, {breq_n_o, bact_n_o}, exp);
        end
    endtask

    task automatic drive(input logic r, input logic gn, input logic bn, input logic eos);
        acc_req_i = r; grant_n_i = gn; busy_n_i = bn; seq_end_i = eos;
    endtask

    // Inputs that keep each state where it is
    task automatic drive_stay(input int s);
        case (s)
            S_IDLE:  drive(1'b0, 1'b1, 1'b1, 1'b1);
            S_WAIT:  drive(1'b1, 1'b1, 1'b1, 1'b1);
            S_ACT:   drive(1'b1, 1'b0, 1'b1, 1'b1);
            default: drive(1'b0, 1'b0, 1'b1, 1'b1);
        endcase
    endtask

    // One edge with given inputs, then one holding edge; the outputs then
    // show the state reached after the first edge.
    task automatic trans(input logic r, input logic gn, input logic bn,
                         input logic eos, input int exp_s, input string tag);
        @(negedge clk); drive(r, gn, bn, eos);
        @(posedge clk);
        @(negedge clk); drive_stay(exp_s);
        @(posedge clk);
        @(negedge clk);
        check(tag, pins_for(exp_s, hold_n_i));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        drive_stay(S_IDLE);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 outputs during reset", 2'b11);
        rst = 1'b0;
        trans(1'b0, 1'b1, 1'b0, 1'b1, S_IDLE, "R1 idle holds, bus not free");
    endtask

    task automatic t_park_loop;
        trans(1'b0, 1'b0, 1'b1, 1'b1, S_PARK, "R2 idle->park");
        trans(1'b0, 1'b0, 1'b0, 1'b1, S_PARK, "R5 park holds");
        trans(1'b1, 1'b0, 1'b0, 1'b1, S_ACT,  "R5 park->active");
        trans(1'b1, 1'b0, 1'b0, 1'b1, S_ACT,  "R6 active holds with grant");
        trans(1'b0, 1'b0, 1'b1, 1'b1, S_PARK, "R6 active->park");
        trans(1'b0, 1'b1, 1'b1, 1'b1, S_IDLE, "R5 park->idle");
    endtask

    task automatic t_wait_path;
        trans(1'b1, 1'b1, 1'b1, 1'b1, S_WAIT, "R2 idle->wait (no grant)");
        trans(1'b1, 1'b0, 1'b0, 1'b1, S_WAIT, "R3 wait holds while busy");
        trans(1'b0, 1'b1, 1'b1, 1'b1, S_WAIT, "R4 dropped request, no idle");
        trans(1'b0, 1'b0, 1'b1, 1'b1, S_WAIT, "R4 dropped request, no park");
        trans(1'b1, 1'b0, 1'b1, 1'b1, S_ACT,  "R3 wait->active");
    endtask

    task automatic t_locked;
        trans(1'b1, 1'b1, 1'b1, 1'b0, S_ACT,  "R7 locked read keeps bus");
        trans(1'b1, 1'b1, 1'b1, 1'b1, S_WAIT, "R7 active->wait at seq end");
        trans(1'b1, 1'b0, 1'b1, 1'b1, S_ACT,  "R3 reacquire");
        trans(1'b0, 1'b1, 1'b1, 1'b0, S_IDLE, "R7 active->idle, no request");
        trans(1'b1, 1'b0, 1'b1, 1'b1, S_ACT,  "R2 idle->active direct");
        trans(1'b0, 1'b0, 1'b1, 1'b1, S_PARK, "R6 active->park again");
        trans(1'b1, 1'b1, 1'b1, 1'b1, S_IDLE, "R5 park->idle, never wait");
    endtask

    task automatic t_hold;
        @(negedge clk); hold_n_i = 1'b0; drive_stay(S_IDLE);
        @(posedge clk); @(negedge clk);
        check("R9 idle copies hold low", 2'b01);
        hold_n_i = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R9 idle copies hold high", 2'b11);
        hold_n_i = 1'b0;
        trans(1'b0, 1'b0, 1'b1, 1'b1, S_PARK, "R9 park copies hold low");
        trans(1'b1, 1'b0, 1'b1, 1'b1, S_ACT,  "R8 active ignores hold");
        trans(1'b1, 1'b1, 1'b1, 1'b1, S_WAIT, "R8 wait ignores hold");
        hold_n_i = 1'b1;
    endtask

    initial begin : watchdog
        #(4 * 20000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_park_loop();
        t_wait_path();
        t_locked();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule